// File: doc/BRIEF.md
# Pulse-Width ID Bus Word Decoder

This block receives a single-wire, open-drain style ID line. Every symbol on the line is a low pulse followed by a high recovery. The block takes the line in through a synchroniser and times each low pulse and each high recovery in clock cycles. It sorts every finished word into one of five kinds: a one bit, a zero bit, a break, a wake, or a malformed pulse.

Bits are collected into bytes. The duration of the recovery after a bit shows whether that bit is the last of its byte. A short recovery is an ordinary bit. A long one is a stop. If the line stays high long enough to reach the timeout, that also closes the word as a stop.

The results come out as one-cycle strobes from registers: a byte strobe with its data, a break strobe, a wake strobe and an error strobe. All time limits are parameters in hundredths of a microsecond. They are scaled by the parameter `CLK_PER_US`.

Top module: `idb_word_decoder`

## Requirements
- R1: A low pulse of 1.00 to 2.50 µs inclusive decodes as a one bit.
- R2: A low pulse of 6.00 to 8.00 µs inclusive decodes as a zero bit.
- R3: A low pulse of 12.00 to 16.00 µs is a break. It raises `brk_o` once when its recovery is at least 2.50 µs, and raises `err_o` instead when the recovery is shorter.
- R4: A low pulse of 22.00 to 27.00 µs raises `wake_o` once.
- R5: A low pulse that fits no window raises `err_o` once, and the partially built byte is discarded.
- R6: The recovery decides whether a bit is a stop bit.
  - A recovery of at least 9.50 µs after a zero bit makes it a stop bit.
  - A recovery of at least 14.75 µs after a one bit makes it a stop bit.
  - Shorter recoveries are ordinary bits.
  - A high time reaching 30 µs closes the pending word as a stop.
- R7: `byte_vld_o` pulses for one cycle only when a stop closes the eighth bit. The first bit received goes to bit 0 of `byte_o`, and `byte_o` holds its value between strobes.
- R8: A stop after fewer than eight bits, or a ninth bit, raises `err_o` and clears the byte in progress.
- R9: A break or a wake discards any partially built byte.
- R10: While reset is held, and afterwards until the line changes, every strobe is low and `byte_o` is zero.
- R11: In any cycle at most one of `byte_vld_o`, `brk_o`, `wake_o` and `err_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| id_i | input | 1 | ID line, asynchronous to the clock, idles high |
| byte_vld_o | output | 1 | One-cycle strobe: `byte_o` holds a new byte |
| byte_o | output | DATA_W | Last byte assembled, first bit received in bit 0 |
| brk_o | output | 1 | One-cycle strobe: a valid break completed |
| wake_o | output | 1 | One-cycle strobe: a wake completed |
| err_o | output | 1 | One-cycle strobe: malformed word or bad bit count |

## Verification
Several internal faults stay invisible until the next byte boundary. A wrong bit counter or a shift in the wrong direction shows at the ports only when the next stop arrives, as a missing byte strobe, a spurious error or a bit-reversed value. Because of this, each scenario ends with a full byte and compares its value.

Off-by-one errors in the window and threshold comparisons show up one word later. The tests drive low pulses and recoveries exactly one cycle on either side of each limit.

A partial byte that survives an error, break or wake shows on the following byte, as an error or a corrupted value.

// File: rtl/idb_pkg.sv
`timescale 1ns/1ps
package idb_pkg;

  // Kind of a completed word on the ID line
  typedef enum logic [2:0] {
    W_BAD  = 3'd0,
    W_BRK  = 3'd1,
    W_WAKE = 3'd2,
    W_ZERO = 3'd3,
    W_ONE  = 3'd4
  } idb_kind_e;

  // Word handed from the classifier to the byte assembler
  typedef struct packed {
    logic      vld;        // one-cycle word completion
    idb_kind_e kind;       // decoded kind
    logic      stop;       // recovery long enough for a byte-ending bit
    logic      rec_short;  // break followed by a too-short recovery
  } idb_word_t;

  // Convert hundredths of a microsecond into clock cycles
  function automatic int cus_to_cyc(input int clk_per_us, input int cus);
    return (clk_per_us * cus) / 100;
  endfunction

endpackage

// File: rtl/idb_sync_edge.sv
`timescale 1ns/1ps
module idb_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic line_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  // Resynchronising chain, reset to the idle-high level
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sh_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], line_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign lvl_o  = sh_q[STAGES-1];
  assign rise_o = lvl_o & ~prev_q;
  assign fall_o = ~lvl_o & prev_q;

endmodule

// File: rtl/idb_interval_timer.sv
`timescale 1ns/1ps
module idb_interval_timer #(
  parameter int CW  = 13,
  parameter int SAT = 6000
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          edge_i,
  output logic [CW-1:0] cnt_o
);

  localparam logic [CW-1:0] SAT_C = CW'(SAT);
  localparam logic [CW-1:0] ONE_C = CW'(1);

  // Cycles elapsed since the last edge, saturating at SAT
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_o <= '0;
    end else if (edge_i) begin
      cnt_o <= ONE_C;
    end else if (cnt_o < SAT_C) begin
      cnt_o <= cnt_o + ONE_C;
    end
  end

endmodule

// File: rtl/idb_word_classifier.sv
`timescale 1ns/1ps
module idb_word_classifier
  import idb_pkg::*;
#(
  parameter int CW        = 13,
  parameter int ONE_MIN   = 200,
  parameter int ONE_MAX   = 500,
  parameter int ZERO_MIN  = 1200,
  parameter int ZERO_MAX  = 1600,
  parameter int BRK_MIN   = 2400,
  parameter int BRK_MAX   = 3200,
  parameter int WAKE_MIN  = 4400,
  parameter int WAKE_MAX  = 5400,
  parameter int ZERO_STOP = 1900,
  parameter int ONE_STOP  = 2950,
  parameter int BRK_REC   = 500,
  parameter int TMO       = 6000
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          lvl_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic [CW-1:0] cnt_i,
  output idb_word_t     word_o
);

  localparam logic [CW-1:0] ONE_MIN_C   = CW'(ONE_MIN);
  localparam logic [CW-1:0] ONE_MAX_C   = CW'(ONE_MAX);
  localparam logic [CW-1:0] ZERO_MIN_C  = CW'(ZERO_MIN);
  localparam logic [CW-1:0] ZERO_MAX_C  = CW'(ZERO_MAX);
  localparam logic [CW-1:0] BRK_MIN_C   = CW'(BRK_MIN);
  localparam logic [CW-1:0] BRK_MAX_C   = CW'(BRK_MAX);
  localparam logic [CW-1:0] WAKE_MIN_C  = CW'(WAKE_MIN);
  localparam logic [CW-1:0] WAKE_MAX_C  = CW'(WAKE_MAX);
  localparam logic [CW-1:0] ZERO_STOP_C = CW'(ZERO_STOP);
  localparam logic [CW-1:0] ONE_STOP_C  = CW'(ONE_STOP);
  localparam logic [CW-1:0] BRK_REC_C   = CW'(BRK_REC);
  localparam logic [CW-1:0] TMO_C       = CW'(TMO);

  logic      pend_q, pend_n;
  idb_kind_e cls_q, cls_n;
  idb_word_t word_n;
  idb_kind_e low_kind;
  logic      close;

  // Window check on the low interval that just ended
  always_comb begin
    if (cnt_i >= ONE_MIN_C && cnt_i <= ONE_MAX_C)        low_kind = W_ONE;
    else if (cnt_i >= ZERO_MIN_C && cnt_i <= ZERO_MAX_C) low_kind = W_ZERO;
    else if (cnt_i >= BRK_MIN_C && cnt_i <= BRK_MAX_C)   low_kind = W_BRK;
    else if (cnt_i >= WAKE_MIN_C && cnt_i <= WAKE_MAX_C) low_kind = W_WAKE;
    else                                                 low_kind = W_BAD;
  end

  // A pending word closes at the next fall or when the high time times out
  assign close = pend_q && (fall_i || (lvl_i && cnt_i == TMO_C));

  always_comb begin
    word_n      = '0;
    word_n.kind = W_BAD;
    pend_n      = pend_q;
    cls_n       = cls_q;
    if (close) begin
      word_n.vld       = 1'b1;
      word_n.kind      = cls_q;
      word_n.stop      = cnt_i >= ((cls_q == W_ONE) ? ONE_STOP_C : ZERO_STOP_C);
      word_n.rec_short = (cls_q == W_BRK) && (cnt_i < BRK_REC_C);
      pend_n           = 1'b0;
    end
    if (rise_i) begin
      if (low_kind == W_BAD) begin
        word_n.vld  = 1'b1;
        word_n.kind = W_BAD;
      end else begin
        pend_n = 1'b1;
        cls_n  = low_kind;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pend_q      <= 1'b0;
      cls_q       <= W_BAD;
      word_o      <= '0;
    end else begin
      pend_q      <= pend_n;
      cls_q       <= cls_n;
      word_o      <= word_n;
    end
  end

  // A malformed word is reported only in the cycle after a rising edge
  assert_bad_on_rise_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (word_o.vld && word_o.kind == W_BAD) |-> $past(rise_i));

  // A word is only pending during high time, except the cycle its closing fall arrives
  assert_pend_high_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (pend_q && !lvl_i) |-> fall_i);

endmodule

// File: rtl/idb_byte_assembler.sv
`timescale 1ns/1ps
module idb_byte_assembler
  import idb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  idb_word_t         word_i,
  output logic              byte_vld_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              brk_o,
  output logic              wake_o,
  output logic              err_o
);

  localparam int            BW     = $clog2(DATA_W + 1);
  localparam logic [BW-1:0] LAST_C = BW'(DATA_W - 1);
  localparam logic [BW-1:0] FULL_C = BW'(DATA_W);

  logic [DATA_W-1:0] sh_q;
  logic [BW-1:0]     bcnt_q;
  logic [DATA_W-1:0] sh_nx;
  logic              bit_v;

  assign bit_v = (word_i.kind == W_ONE);
  assign sh_nx = {bit_v, sh_q[DATA_W-1:1]};

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sh_q       <= '0;
      bcnt_q     <= '0;
      byte_o     <= '0;
      byte_vld_o <= 1'b0;
      brk_o      <= 1'b0;
      wake_o     <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      brk_o      <= 1'b0;
      wake_o     <= 1'b0;
      err_o      <= 1'b0;
      if (word_i.vld) begin
        unique case (word_i.kind)
          W_BRK: begin
            bcnt_q <= '0;
            if (word_i.rec_short) err_o <= 1'b1;
            else                  brk_o <= 1'b1;
          end
          W_WAKE: begin
            bcnt_q <= '0;
            wake_o <= 1'b1;
          end
          W_ZERO, W_ONE: begin
            if (bcnt_q == FULL_C) begin
              bcnt_q <= '0;
              err_o  <= 1'b1;
            end else if (word_i.stop) begin
              bcnt_q <= '0;
              if (bcnt_q == LAST_C) begin
                byte_o     <= sh_nx;
                byte_vld_o <= 1'b1;
              end else begin
                err_o <= 1'b1;
              end
            end else begin
              sh_q   <= sh_nx;
              bcnt_q <= bcnt_q + BW'(1);
            end
          end
          default: begin
            bcnt_q <= '0;
            err_o  <= 1'b1;
          end
        endcase
      end
    end
  end

  assert_strobe_excl_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0({byte_vld_o, brk_o, wake_o, err_o}));

  assert_byte_len_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    byte_vld_o |-> $past(bcnt_q) == LAST_C);

  assert_byte_hold_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    !byte_vld_o |-> $stable(byte_o));

  assert_err_flush_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    err_o |-> bcnt_q == '0);

  assert_brk_flush_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (brk_o || wake_o) |-> bcnt_q == '0);

endmodule

// File: rtl/idb_word_decoder.sv
`timescale 1ns/1ps
module idb_word_decoder
  import idb_pkg::*;
#(
  parameter int CLK_PER_US    = 200,
  parameter int DATA_W        = 8,
  parameter int SYNC_STAGES   = 2,
  parameter int ONE_MIN_CUS   = 100,
  parameter int ONE_MAX_CUS   = 250,
  parameter int ZERO_MIN_CUS  = 600,
  parameter int ZERO_MAX_CUS  = 800,
  parameter int BRK_MIN_CUS   = 1200,
  parameter int BRK_MAX_CUS   = 1600,
  parameter int WAKE_MIN_CUS  = 2200,
  parameter int WAKE_MAX_CUS  = 2700,
  parameter int ZERO_STOP_CUS = 950,
  parameter int ONE_STOP_CUS  = 1475,
  parameter int BRK_REC_CUS   = 250,
  parameter int TMO_CUS       = 3000
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              id_i,
  output logic              byte_vld_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              brk_o,
  output logic              wake_o,
  output logic              err_o
);

  localparam int TMO_CYC = cus_to_cyc(CLK_PER_US, TMO_CUS);
  localparam int CW      = $clog2(TMO_CYC + 1);

  logic          lvl, rise, fall;
  logic [CW-1:0] cnt;
  idb_word_t     word;

  idb_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .line_i (id_i),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  idb_interval_timer #(.CW(CW), .SAT(TMO_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .edge_i (rise | fall),
    .cnt_o  (cnt)
  );

  idb_word_classifier #(
    .CW        (CW),
    .ONE_MIN   (cus_to_cyc(CLK_PER_US, ONE_MIN_CUS)),
    .ONE_MAX   (cus_to_cyc(CLK_PER_US, ONE_MAX_CUS)),
    .ZERO_MIN  (cus_to_cyc(CLK_PER_US, ZERO_MIN_CUS)),
    .ZERO_MAX  (cus_to_cyc(CLK_PER_US, ZERO_MAX_CUS)),
    .BRK_MIN   (cus_to_cyc(CLK_PER_US, BRK_MIN_CUS)),
    .BRK_MAX   (cus_to_cyc(CLK_PER_US, BRK_MAX_CUS)),
    .WAKE_MIN  (cus_to_cyc(CLK_PER_US, WAKE_MIN_CUS)),
    .WAKE_MAX  (cus_to_cyc(CLK_PER_US, WAKE_MAX_CUS)),
    .ZERO_STOP (cus_to_cyc(CLK_PER_US, ZERO_STOP_CUS)),
    .ONE_STOP  (cus_to_cyc(CLK_PER_US, ONE_STOP_CUS)),
    .BRK_REC   (cus_to_cyc(CLK_PER_US, BRK_REC_CUS)),
    .TMO       (TMO_CYC)
  ) u_class (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .lvl_i  (lvl),
    .rise_i (rise),
    .fall_i (fall),
    .cnt_i  (cnt),
    .word_o (word)
  );

  idb_byte_assembler #(.DATA_W(DATA_W)) u_asm (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .word_i     (word),
    .byte_vld_o (byte_vld_o),
    .byte_o     (byte_o),
    .brk_o      (brk_o),
    .wake_o     (wake_o),
    .err_o      (err_o)
  );

  // A break or wake strobe must follow a word the classifier handed over
  assert_event_source_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (brk_o || wake_o) |-> $past(word.vld));

endmodule

// File: tb/idb_word_decoder_tb.sv
`timescale 1ns/1ps
module idb_word_decoder_tb;

  // 20 cycles per microsecond keeps runs short; the clock itself is 200 MHz
  localparam int CPU = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       id  = 1'b1;
  logic       byte_vld, brk, wake, err;
  logic [7:0] byte_d;

  int n_chk = 0, n_fail = 0;
  int n_byte = 0, n_brk = 0, n_wake = 0, n_err = 0, n_ovl = 0;
  logic [7:0] last_byte = 8'h00;
  bit done = 0;

  always #2.5 clk = ~clk;

  idb_word_decoder #(.CLK_PER_US(CPU)) u_dut (
    .clk_i(clk), .rst_i(rst), .id_i(id),
    .byte_vld_o(byte_vld), .byte_o(byte_d),
    .brk_o(brk), .wake_o(wake), .err_o(err)
  );

  // Event monitor, sampling away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (byte_vld) begin n_byte++; last_byte = byte_d; end
      if (brk)  n_brk++;
      if (wake) n_wake++;
      if (err)  n_err++;
      if ((int'(byte_vld) + int'(brk) + int'(wake) + int'(err)) > 1) n_ovl++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic lo(input int n);
    id = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic hi(input int n);
    id = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic bitw(input bit b, input int low, input int high);
    lo(low);
    hi(high);
  endtask

  // Typical timing: one = 1.7/8.5 (stop 21), zero = 7/3 (stop 16) us
  task automatic send_byte(input logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      if (d[i]) bitw(1'b1, 34,  (i == 7) ? 420 : 170);
      else      bitw(1'b0, 140, (i == 7) ? 320 : 60);
    end
  endtask

  task automatic send_bits(input logic [7:0] d, input int n);
    for (int i = 0; i < n; i++) begin
      if (d[i]) bitw(1'b1, 34, 170);
      else      bitw(1'b0, 140, 60);
    end
  endtask

  task automatic settle();
    hi(700);
  endtask

  // Snapshots of the monitor counters at the start of each step
  int b0, k0, w0, e0;
  task automatic snap();
    b0 = n_byte; k0 = n_brk; w0 = n_wake; e0 = n_err;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk({byte_vld, brk, wake, err} == 4'b0 && byte_d == 8'h00, "R10 in reset",
        {byte_vld, brk, wake, err, byte_d}, 0);
    rst = 1'b0;
    hi(50);
    chk({byte_vld, brk, wake, err} == 4'b0 && byte_d == 8'h00 && n_err == 0,
        "R10 after reset", {byte_vld, brk, wake, err, byte_d}, 0);
  endtask

  task automatic t_bytes();
    logic [7:0] pats [4] = '{8'hA5, 8'h3C, 8'h00, 8'hFF};
    foreach (pats[i]) begin
      snap();
      send_byte(pats[i]);
      settle();
      chk(n_byte == b0 + 1 && last_byte == pats[i] && n_err == e0,
          "R1 R2 R7 byte value", last_byte, pats[i]);
    end
    snap();
    send_byte(8'h12);
    send_byte(8'h34);
    settle();
    chk(n_byte == b0 + 2 && last_byte == 8'h34, "R7 back-to-back", n_byte - b0, 2);
  endtask

  task automatic t_window_edges();
    snap();
    bitw(1'b1, 20, 170);   // one at min low
    bitw(1'b0, 120, 60);   // zero at min low
    bitw(1'b1, 50, 170);   // one at max low
    bitw(1'b0, 160, 60);   // zero at max low
    send_bits(8'h0F, 3);
    bitw(1'b1, 34, 420);
    settle();
    chk(n_byte == b0 + 1 && last_byte == 8'hF5 && n_err == e0,
        "R1 R2 window limits", last_byte, 8'hF5);
  endtask

  task automatic t_reject();
    int bad [8] = '{19, 51, 119, 161, 239, 321, 439, 541};
    foreach (bad[i]) begin
      snap();
      lo(bad[i]);
      settle();
      chk(n_err == e0 + 1 && n_byte == b0 && n_brk == k0 && n_wake == w0,
          "R5 out-of-window low", bad[i], 0);
    end
    snap();
    send_bits(8'h07, 3);
    lo(90);
    hi(60);
    send_byte(8'h5A);
    settle();
    chk(n_err == e0 + 1 && n_byte == b0 + 1 && last_byte == 8'h5A,
        "R5 partial byte flushed", last_byte, 8'h5A);
  endtask

  task automatic t_break();
    int ok_lows [3] = '{240, 280, 320};
    foreach (ok_lows[i]) begin
      snap();
      lo(ok_lows[i]);
      settle();
      chk(n_brk == k0 + 1 && n_err == e0, "R3 break window", ok_lows[i], 0);
    end
    snap();
    lo(280); hi(49);
    lo(280); hi(50);
    send_byte(8'h81);
    settle();
    chk(n_err == e0 + 1 && n_brk == k0 + 1, "R3 break recovery limit", n_brk - k0, 1);
    chk(n_byte == b0 + 1 && last_byte == 8'h81, "R3 byte after break", last_byte, 8'h81);
  endtask

  task automatic t_wake();
    int lows [3] = '{440, 480, 540};
    foreach (lows[i]) begin
      snap();
      lo(lows[i]);
      settle();
      chk(n_wake == w0 + 1 && n_err == e0 && n_brk == k0, "R4 wake window", lows[i], 0);
    end
  endtask

  task automatic t_stop_thresh();
    snap();
    send_bits(8'h00, 6);
    bitw(1'b0, 140, 189);  // just below zero stop: plain bit
    bitw(1'b1, 34, 420);
    settle();
    chk(n_byte == b0 + 1 && last_byte == 8'h80 && n_err == e0,
        "R6 zero below stop", last_byte, 8'h80);
    snap();
    send_bits(8'h00, 7);
    bitw(1'b0, 140, 190);  // exactly at zero stop
    lo(280);
    settle();
    chk(n_byte == b0 + 1 && last_byte == 8'h00 && n_brk == k0 + 1 && n_err == e0,
        "R6 zero at stop", n_err - e0, 0);
    snap();
    send_bits(8'h3F, 6);
    bitw(1'b1, 34, 294);   // just below one stop
    bitw(1'b1, 34, 295);   // exactly at one stop
    lo(280);
    settle();
    chk(n_byte == b0 + 1 && last_byte == 8'hFF && n_brk == k0 + 1 && n_err == e0,
        "R6 one thresholds", last_byte, 8'hFF);
    snap();
    send_bits(8'h4C, 7);
    lo(34);                // last bit: line then stays high until timeout
    settle();
    chk(n_byte == b0 + 1 && last_byte == 8'hCC, "R6 timeout closes word", last_byte, 8'hCC);
  endtask

  task automatic t_count_err();
    snap();
    send_bits(8'h00, 4);
    bitw(1'b1, 34, 420);
    settle();
    chk(n_err == e0 + 1 && n_byte == b0, "R8 short byte", n_err - e0, 1);
    snap();
    send_bits(8'hFF, 8);
    bitw(1'b0, 140, 60);
    settle();
    chk(n_err == e0 + 1 && n_byte == b0, "R8 ninth bit", n_err - e0, 1);
    snap();
    send_byte(8'h96);
    settle();
    chk(n_byte == b0 + 1 && last_byte == 8'h96 && n_err == e0, "R8 recovery", last_byte, 8'h96);
  endtask

  task automatic t_flush_events();
    snap();
    send_bits(8'h05, 3);
    lo(280); hi(100);
    send_byte(8'h6E);
    settle();
    chk(n_byte == b0 + 1 && last_byte == 8'h6E && n_err == e0 && n_brk == k0 + 1,
        "R9 break flushes", last_byte, 8'h6E);
    snap();
    send_bits(8'h02, 5);
    lo(480); hi(200);
    send_byte(8'hC3);
    settle();
    chk(n_byte == b0 + 1 && last_byte == 8'hC3 && n_err == e0 && n_wake == w0 + 1,
        "R9 wake flushes", last_byte, 8'hC3);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_bytes();
    t_window_edges();
    t_reject();
    t_break();
    t_wake();
    t_stop_thresh();
    t_count_err();
    t_flush_events();
    chk(n_ovl == 0, "R11 strobe exclusivity", n_ovl, 0);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule